// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read-side sequencer of a synchronous burst memory. A burst opens on the clock edge where the enable input and the address-valid input are both high. The block captures the start address on that edge. It then presents consecutive words from a small internal word array, one word per data cycle. A data cycle lasts one or two clocks, chosen by a configuration bit.

Alongside the data, the block drives a WAIT flag that tells the host when the output is not usable. This happens during the initial latency and at the single stall inserted each time the burst steps across a 16-word row.

A 16-bit configuration register governs the behaviour:
- the WAIT polarity;
- whether WAIT marks the stall itself or is raised one data cycle ahead of it;
- the data hold length;
- the initial latency.

The register can only be written while the sequencer is idle. Dropping the enable input ends a burst at once.

Top module: `sbw_burst_rd`

## Requirements
- R1: Config bit 10 sets the WAIT polarity. When it is 1, wait_o is high when asserted. When it is 0, wait_o is low when asserted. When wait_o is not asserted it sits at the opposite level.
- R2: With config bit 8 at 0 and a burst running, WAIT is asserted in exactly those data cycles in which rd_valid is low.
- R3: Config bit 9 sets the data hold. At 0, each word is presented for one clock. At 1, each word is presented for two clocks, and the latency and address stepping count data cycles instead of clocks.
- R4: With config bit 8 at 1, WAIT in each data cycle reflects whether the following data cycle is a stall. WAIT therefore rises one data cycle before a stall and falls one data cycle before valid data resumes.
- R5: Config bit 7 always reads back as 1, whatever value is written to it.
- R6: Config bits [13:11] give the latency L in data cycles. The L data cycles after the capture edge are stalls and the next one carries the first word. Field values 0 and 1 behave as 2.
- R7: A burst starts on a clock edge with ce and adv both high, and addr_in is captured there. The words that follow come from consecutive addresses. The word at address A is {A, ~A}, with A in the upper half of dout.
- R8: After the word whose low 4 address bits are 15, exactly one stall data cycle is inserted before the next word.
- R9: A clock edge with ce low ends any burst. From the following cycle, rd_valid is 0 and wait_o sits at its inactive level.
- R10: A write strobe on a clock edge where a burst is active or starting leaves the register unchanged.
- R11: After reset the register reads 16'h3A80: latency 7, WAIT active low, two-clock hold, WAIT during the stall, bit 7 set. In the same state rd_valid is 0 and wait_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration register contents |
| ce | input | 1 | Enable; low ends a burst |
| adv | input | 1 | Address valid; with ce opens a burst |
| addr_in | input | AW | Burst start address |
| dout | output | DW | Word being presented (0 when not valid) |
| rd_valid | output | 1 | High while dout carries a valid word |
| wait_o | output | 1 | WAIT flag, polarity per config bit 10 |

## Verification
Each burst is run under a different configuration, and the results are compared clock by clock against a queue of expected values:
- A one-clock burst whose start is just below a row boundary separates a correct stall from a missing or doubled one.
- A burst with reversed polarity and early WAIT shows whether WAIT follows the next slot rather than the current one.
- A two-clock hold burst that wraps the whole address space separates per-clock counting from per-data-cycle counting.
- A burst with latency field 0 checks the clamp to 2.
- Very short bursts show that a dropped enable cuts off the latency phase.
- A register write attempted mid-burst is read back afterwards to confirm it was refused.

// File: rtl/sbw_pkg.sv
// Shared definitions for the synchronous burst read sequencer.
// Assumes a 16-bit configuration register with fixed field positions.
package sbw_pkg;
    localparam int CFG_W      = 16;
    localparam int LAT_LSB    = 11;
    localparam int POL_BIT    = 10;
    localparam int HOLD_BIT   = 9;
    localparam int EARLY_BIT  = 8;
    localparam int SEQ_BIT    = 7;
    localparam logic [CFG_W-1:0] CFG_RESET = 16'h3A80;

    // Decoded view of the configuration register.
    typedef struct packed {
        logic [2:0] lat;
        logic       pol;
        logic       hold2;
        logic       early;
    } cfg_t;
endpackage

// File: rtl/sbw_cfg_reg.sv
// Configuration register. Loads only when not locked, and forces the
// sequential-burst bit high. Assumes the lock is high while a burst is active or starting.
module sbw_cfg_reg
    import sbw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             lock,
    output logic [CFG_W-1:0] rdata,
    output cfg_t             cfg
);
    logic [CFG_W-1:0] reg_q;

    // Register update: reset default, or accept a write while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= CFG_RESET;
        else if (we && !lock)
            reg_q <= wdata | (CFG_W'(1) << SEQ_BIT);
    end

    // Field decode for the sequencer and the output stage.
    always_comb begin
        cfg.lat   = reg_q[LAT_LSB +: 3];
        cfg.pol   = reg_q[POL_BIT];
        cfg.hold2 = reg_q[HOLD_BIT];
        cfg.early = reg_q[EARLY_BIT];
    end

    assign rdata = reg_q;
endmodule

// File: rtl/sbw_slot_seq.sv
// Data-cycle sequencer. Keeps the current slot and the slot after it
// (valid flag plus address), the latency countdown, the row-gap flag and the hold phase.
// Assumes the config stays stable while busy.
module sbw_slot_seq #(
    parameter int AW    = 8,
    parameter int ROW_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ce,
    input  logic [AW-1:0] addr_in,
    input  logic [2:0]    lat,
    input  logic          hold2,
    output logic          busy,
    output logic          cur_v,
    output logic [AW-1:0] cur_a,
    output logic          nxt_v
);
    logic [AW-1:0] nxt_a;
    logic [AW-1:0] gaddr;
    logic [2:0]    lat_left;
    logic          gap;
    logic          hph;
    logic [2:0]    lat_eff;
    logic          slot_end;

    // Latency clamp and data-cycle boundary detect.
    always_comb begin
        lat_eff  = (lat < 3'd2) ? 3'd2 : lat;
        slot_end = !hold2 || hph;
    end

    // Slot pipeline: start, abort on ce low, or advance at each slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; cur_v <= 1'b0; nxt_v <= 1'b0;
            cur_a <= '0; nxt_a <= '0; gaddr <= '0;
            lat_left <= '0; gap <= 1'b0; hph <= 1'b0;
        end else if (start) begin
            busy <= 1'b1; cur_v <= 1'b0; nxt_v <= 1'b0;
            gaddr <= addr_in; lat_left <= lat_eff - 3'd2;
            gap <= 1'b0; hph <= 1'b0;
        end else if (!ce) begin
            busy <= 1'b0; cur_v <= 1'b0; nxt_v <= 1'b0; hph <= 1'b0;
        end else if (busy) begin
            if (slot_end) begin
                hph   <= 1'b0;
                cur_v <= nxt_v;
                cur_a <= nxt_a;
                if (lat_left != 3'd0) begin
                    nxt_v    <= 1'b0;
                    lat_left <= lat_left - 3'd1;
                end else if (gap) begin
                    nxt_v <= 1'b0;
                    gap   <= 1'b0;
                end else begin
                    nxt_v <= 1'b1;
                    nxt_a <= gaddr;
                    gaddr <= gaddr + AW'(1);
                    gap   <= (gaddr[ROW_W-1:0] == {ROW_W{1'b1}});
                end
            end else begin
                hph <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbw_word_src.sv
// Internal word array, computed from the address: the upper AW bits are
// the address and the lower AW bits its complement. Assumes DW == 2*AW.
module sbw_word_src #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] word
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i < AW) begin : g_lo
            assign word[i] = ~addr[i % AW];
        end else begin : g_hi
            assign word[i] = addr[i % AW];
        end
    end
endmodule

// File: rtl/sbw_burst_rd.sv
// Top of the synchronous burst read sequencer. Ties the config register,
// the slot sequencer and the word array together, and forms WAIT from
// polarity and timing. Assumes ce/adv are synchronous to clk.
module sbw_burst_rd
    import sbw_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             ce,
    input  logic             adv,
    input  logic [AW-1:0]    addr_in,
    output logic [DW-1:0]    dout,
    output logic             rd_valid,
    output logic             wait_o
);
    cfg_t          cfg;
    logic          start;
    logic          busy;
    logic          cur_v;
    logic          nxt_v;
    logic [AW-1:0] cur_a;
    logic [DW-1:0] word;
    logic          stall_act;

    assign start = ce && adv;

    sbw_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .lock(busy || start), .rdata(cfg_rdata), .cfg(cfg)
    );

    sbw_slot_seq #(.AW(AW), .ROW_W(ROW_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ce(ce), .addr_in(addr_in),
        .lat(cfg.lat), .hold2(cfg.hold2), .busy(busy),
        .cur_v(cur_v), .cur_a(cur_a), .nxt_v(nxt_v)
    );

    sbw_word_src #(.AW(AW), .DW(DW)) u_word (.addr(cur_a), .word(word));

    // Output stage: pick stall view (current or next slot), apply polarity.
    always_comb begin
        stall_act = busy && (cfg.early ? !nxt_v : !cur_v);
        wait_o    = cfg.pol ? stall_act : !stall_act;
        rd_valid  = cur_v;
        dout      = cur_v ? word : '0;
    end
endmodule

// File: rtl/sbw_burst_rd_chk.sv
// Property checker for sbw_burst_rd, attached with bind. Observes ports only.
module sbw_burst_rd_chk #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int ROW_W = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          cfg_pol,
    input logic          cfg_hold,
    input logic          cfg_early,
    input logic [15:0]   cfg_rdata,
    input logic          ce,
    input logic          adv,
    input logic [DW-1:0] dout,
    input logic          rd_valid,
    input logic          wait_o
);
    a_r9_ce_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> (!rd_valid && (wait_o == !cfg_pol)));

    a_r2_valid_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !cfg_early) |-> (wait_o == !cfg_pol));

    a_r10_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && rd_valid) |=> $stable(cfg_rdata));

    a_r3_two_clock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_valid) && cfg_hold && ce && !adv) |=> (rd_valid && $stable(dout)));

    a_r8_row_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !cfg_hold && ce && !adv &&
         dout[AW +: ROW_W] == {ROW_W{1'b1}}) |=> !rd_valid);
endmodule

bind sbw_burst_rd sbw_burst_rd_chk #(.AW(AW), .DW(DW), .ROW_W(ROW_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_pol(cfg_rdata[10]), .cfg_hold(cfg_rdata[9]), .cfg_early(cfg_rdata[8]),
    .cfg_rdata(cfg_rdata), .ce(ce), .adv(adv), .dout(dout),
    .rd_valid(rd_valid), .wait_o(wait_o)
);

// File: tb/sbw_burst_rd_tb.sv
`timescale 1ns/1ps
module sbw_burst_rd_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic          ce = 1'b0;
    logic          adv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] dout;
    logic          rd_valid;
    logic          wait_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    string cur_tag = "";

    typedef struct {
        logic          v;
        logic          w;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    sbw_burst_rd dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ce(ce), .adv(adv), .addr_in(addr_in),
        .dout(dout), .rd_valid(rd_valid), .wait_o(wait_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per falling edge and compares.
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            check(rd_valid === e.v && wait_o === e.w && (!e.v || dout === e.d),
                  e.tag, "valid/wait/data",
                  {14'd0, rd_valid, wait_o, dout}, {14'd0, e.v, e.w, e.d});
        end
    end

    task automatic cfg_write(input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: builds the expected slot stream from the requirements,
    // opens a burst, holds it for nclk clocks, then drops ce.
    task automatic burst(input logic [15:0] cw, input logic [7:0] a,
                         input int nclk, input bit poke, input string tag);
        int   lat, hold, ns;
        bit   pol, early, gap;
        logic [7:0] ga;
        bit         sv[$];
        logic [7:0] sa[$];
        lat   = int'(cw[13:11]);
        if (lat < 2) lat = 2;
        pol   = cw[10];
        hold  = cw[9] ? 2 : 1;
        early = cw[8];
        ns    = nclk / hold + 3;
        for (int s = 0; s < lat; s++) begin sv.push_back(1'b0); sa.push_back(8'h00); end
        ga = a; gap = 1'b0;
        while (sv.size() < ns) begin
            if (gap) begin
                sv.push_back(1'b0); sa.push_back(8'h00); gap = 1'b0;
            end else begin
                sv.push_back(1'b1); sa.push_back(ga);
                gap = (ga[3:0] == 4'hF);
                ga = ga + 8'd1;
            end
        end
        @(negedge clk);
        ce = 1'b1; adv = 1'b1; addr_in = a;
        @(posedge clk);
        for (int k = 0; k < nclk; k++) begin
            exp_t e;
            int s;
            bit act;
            s = k / hold;
            act = early ? !sv[s+1] : !sv[s];
            e.v = sv[s];
            e.w = pol ? act : !act;
            e.d = {sa[s], ~sa[s]};
            e.tag = tag;
            expq.push_back(e);
        end
        begin
            exp_t e;
            e.v = 1'b0; e.w = !pol; e.d = '0; e.tag = {tag, "/R9"};
            expq.push_back(e);
        end
        for (int k = 0; k < nclk; k++) begin
            @(negedge clk);
            if (k == 0) adv = 1'b0;
            if (poke && k == 2) begin cfg_we = 1'b1; cfg_wdata = 16'hFFFF; end
            if (poke && k == 3) cfg_we = 1'b0;
        end
        ce = 1'b0; adv = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(cfg_rdata === 16'h3A80, "R11", "cfg reset", {16'd0, cfg_rdata}, 32'h3A80);
        check(rd_valid === 1'b0, "R11", "idle valid", {31'd0, rd_valid}, 32'd0);
        check(wait_o === 1'b1, "R11", "idle wait", {31'd0, wait_o}, 32'd1);

        // R5: bit 7 forced high
        cfg_write(16'h1000);
        check(cfg_rdata === 16'h1080, "R5", "seq bit readback", {16'd0, cfg_rdata}, 32'h1080);

        // R2 R6 R7 R8: latency 2, one-clock hold, crosses a row
        burst(16'h1080, 8'h05, 24, 1'b0, "R2/R7/R8");

        // R1 R4: active-high WAIT, early timing, latency 3
        cfg_write(16'h1D80);
        burst(16'h1D80, 8'h0D, 16, 1'b0, "R1/R4");

        // R3: two-clock hold, latency 4, wraps address space
        cfg_write(16'h2280);
        burst(16'h2280, 8'hFE, 30, 1'b0, "R3");

        // R6: latency field 0 behaves as 2
        cfg_write(16'h0080);
        burst(16'h0080, 8'h20, 8, 1'b0, "R6");

        // R9: ce dropped during latency
        burst(16'h0080, 8'h40, 1, 1'b0, "R9");
        cfg_write(16'h3A80);
        burst(16'h3A80, 8'h31, 6, 1'b0, "R9/R11");

        // R10: write attempted mid-burst is refused
        cfg_write(16'h1080);
        burst(16'h1080, 8'h0E, 8, 1'b1, "R10");
        check(cfg_rdata === 16'h1080, "R10", "cfg after blocked write",
              {16'd0, cfg_rdata}, 32'h1080);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule